// File: doc/BRIEF.md
# Receive Holding Queue with Break Injection

This block is a small receive queue placed between a serial deserializer and the register controller of a UART. The line side offers one byte per cycle together with a valid strobe, and a separate strobe reports a break condition on the line. The register side removes the oldest held byte when the receive data register is read, and it can also flush the queue with a receiver reset command.

The queue tracks three flags for the register controller: receive ready (something is held), full (every slot is occupied), and a sticky delta-break flag that records a break until software clears it. The queue also tells the deserializer, through an accept output, whether a new byte may be offered. A break always lands in the queue as a zero byte, even when the queue is full, so that software sees the break in the byte stream. Interrupt masking, framing and error flags belong to other blocks.

Top module: `rx_hold_queue`

## Requirements
- R1: After reset the queue is empty, the ready, full and delta-break flags are 0, and the read data output is 0x00.
- R2: Bytes leave the queue in the order they arrived, and the queue holds at most DEPTH bytes (four by default).
- R3: Every accepted push sets the ready flag, and the full flag is set in the cycle after the held count reaches DEPTH.
- R4: A pop of a held byte clears the full flag, and it clears the ready flag only when it takes the last held byte.
- R5: A pop while the queue is empty returns 0x00 on the read data output and leaves the flags and the contents unchanged.
- R6: A break strobe pushes a 0x00 byte and sets the delta-break flag; when the queue already holds DEPTH bytes and no pop occurs, the 0x00 replaces the newest byte and the count stays at DEPTH.
- R7: The accept output is 1 only when the receiver enable input is 1 and the full flag is 0; a line byte offered while accept is 0 is dropped.
- R8: A receiver reset strobe empties the queue and clears the ready and full flags in the next cycle.
- R9: A pop and a push in the same cycle both take effect: the count is unchanged, the oldest byte leaves and the new byte joins at the back.
- R10: The delta-break flag stays set until the clear strobe; if a break and the clear strobe arrive together the flag stays set.
- R11: When a break and a line byte arrive in the same cycle, only the 0x00 break byte enters the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receiver enabled by the register controller |
| line_valid_i | input | 1 | Deserializer offers a byte this cycle |
| line_data_i | input | DATA_W | Byte offered by the deserializer |
| line_break_i | input | 1 | Break detected on the line this cycle |
| accept_o | output | 1 | A line byte would be taken this cycle |
| pop_i | input | 1 | Receive data register read; removes the oldest byte |
| rd_data_o | output | DATA_W | Oldest held byte, 0x00 when empty |
| flush_i | input | 1 | Receiver reset command |
| brk_clr_i | input | 1 | Clear the delta-break flag |
| ready_o | output | 1 | At least one byte is held |
| full_o | output | 1 | DEPTH bytes are held |
| brk_flag_o | output | 1 | Delta-break flag |

## Verification
The bench builds the queue with its defaults, DEPTH of four and DATA_W of eight, so a full queue is reached after four pushes and both pointers wrap within one fill-and-drain pass. That puts the overwrite-on-break path, the push dropped while full, and a simultaneous pop and push on a wrapped pointer all within a few dozen cycles. Each of these is driven by a directed task that then drains the queue through the read port to show what it held.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned DEPTH_DEF  = 4;

  typedef enum logic [2:0] {
    Q_IDLE,
    Q_PUSH,
    Q_POP,
    Q_BOTH,
    Q_REPLACE,
    Q_FLUSH
  } q_act_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == PTR_W'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              line_valid_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              line_break_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic              accept_o,
  output logic              we_o,
  output logic [PTR_W-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [PTR_W-1:0]  raddr_o,
  output logic              ready_o,
  output logic              full_o
);
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             ready_q, full_q;
  logic             do_pop, line_push, push_req, replace;
  q_act_e           act;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign accept_o  = rx_en_i && !full_q;
  assign do_pop    = pop_i && (cnt_q != '0);
  assign line_push = line_valid_i && accept_o;
  assign push_req  = line_break_i || line_push;
  // full queue, no pop: break overwrites the newest slot
  assign replace   = line_break_i && (cnt_q == CNT_W'(DEPTH)) && !do_pop;

  always_comb begin
    if (flush_i)                 act = Q_FLUSH;
    else if (replace)            act = Q_REPLACE;
    else if (push_req && do_pop) act = Q_BOTH;
    else if (push_req)           act = Q_PUSH;
    else if (do_pop)             act = Q_POP;
    else                         act = Q_IDLE;
  end

  always_comb begin
    unique case (act)
      Q_FLUSH: cnt_nxt = '0;
      Q_PUSH:  cnt_nxt = cnt_q + 1'b1;
      Q_POP:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  assign we_o    = push_req && !flush_i;
  assign waddr_o = replace ? ptr_dec(wr_ptr_q) : wr_ptr_q;
  assign wdata_o = line_break_i ? '0 : line_data_i;
  assign raddr_o = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      ready_q  <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ready_q <= (cnt_nxt != '0);
      full_q  <= (cnt_nxt == CNT_W'(DEPTH));
      unique case (act)
        Q_FLUSH: begin
          rd_ptr_q <= '0;
          wr_ptr_q <= '0;
        end
        Q_PUSH:  wr_ptr_q <= ptr_inc(wr_ptr_q);
        Q_POP:   rd_ptr_q <= ptr_inc(rd_ptr_q);
        Q_BOTH: begin
          wr_ptr_q <= ptr_inc(wr_ptr_q);
          rd_ptr_q <= ptr_inc(rd_ptr_q);
        end
        default: ;
      endcase
    end
  end

  assign ready_o = ready_q;
  assign full_o  = full_q;

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  a_r3_push_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && !flush_i) |=> ready_q);

  a_r4_pop_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && !line_break_i && !flush_i) |=> !full_q);

  a_r5_empty_pop_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == '0 && !push_req && !flush_i) |=> ($stable(cnt_q) && $stable(rd_ptr_q)));

  a_r6_replace_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_break_i && full_q && !pop_i && !flush_i) |=> (full_q && $stable(wr_ptr_q)));

  a_r7_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !line_break_i && !pop_i && !flush_i) |=> $stable(cnt_q));

  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!ready_q && !full_q && cnt_q == '0));

  a_r9_both_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && push_req && !flush_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              line_valid_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              line_break_i,
  output logic              accept_o,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              flush_i,
  input  logic              brk_clr_i,
  output logic              ready_o,
  output logic              full_o,
  output logic              brk_flag_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              we;
  logic [PTR_W-1:0]  waddr, raddr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              brk_q;

  rxq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_en_i      (rx_en_i),
    .line_valid_i (line_valid_i),
    .line_data_i  (line_data_i),
    .line_break_i (line_break_i),
    .pop_i        (pop_i),
    .flush_i      (flush_i),
    .accept_o     (accept_o),
    .we_o         (we),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .raddr_o      (raddr),
    .ready_o      (ready_o),
    .full_o       (full_o)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign rd_data_o = ready_o ? rdata : '0;

  // break set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           brk_q <= 1'b0;
    else if (line_break_i) brk_q <= 1'b1;
    else if (brk_clr_i)    brk_q <= 1'b0;
  end

  assign brk_flag_o = brk_q;

  a_r10_break_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_break_i |=> brk_flag_o);

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_break_i && !brk_clr_i) |=> $stable(brk_flag_o));

  a_r5_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (rd_data_o == '0));
endmodule

// File: tb/rx_hold_queue_test.sv
module rx_hold_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0, line_valid = 1'b0, line_break = 1'b0;
  logic [DW-1:0] line_data = '0;
  logic          pop = 1'b0, flush = 1'b0, brk_clr = 1'b0;
  logic          accept, ready, full, brk_flag;
  logic [DW-1:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hold_queue uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_en_i      (rx_en),
    .line_valid_i (line_valid),
    .line_data_i  (line_data),
    .line_break_i (line_break),
    .accept_o     (accept),
    .pop_i        (pop),
    .rd_data_o    (rd_data),
    .flush_i      (flush),
    .brk_clr_i    (brk_clr),
    .ready_o      (ready),
    .full_o       (full),
    .brk_flag_o   (brk_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs change on the falling edge; outputs sampled there too
  task automatic push_byte(input logic [DW-1:0] d);
    line_valid = 1'b1; line_data = d;
    @(negedge clk);
    line_valid = 1'b0;
  endtask

  task automatic send_break();
    line_break = 1'b1;
    @(negedge clk);
    line_break = 1'b0;
  endtask

  task automatic pop_check(input string tag, input logic [DW-1:0] exp);
    check(tag, rd_data, exp);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready", ready, 0);
    check("R1 full", full, 0);
    check("R1 brk", brk_flag, 0);
    check("R1 data", rd_data, 8'h00);
  endtask

  task automatic t_order();
    push_byte(8'h11);
    check("R3 ready after push", ready, 1);
    check("R3 not full", full, 0);
    push_byte(8'h22);
    push_byte(8'h33);
    check("R3 not full at 3", full, 0);
    push_byte(8'h44);
    check("R3 full at 4", full, 1);
    check("R7 accept low when full", accept, 0);
    push_byte(8'h55);
    check("R7 still full", full, 1);
    pop_check("R2 first", 8'h11);
    check("R4 full cleared", full, 0);
    check("R4 ready kept", ready, 1);
    check("R7 accept back", accept, 1);
    pop_check("R2 second", 8'h22);
    pop_check("R2 third", 8'h33);
    pop_check("R7 dropped byte absent", 8'h44);
    check("R4 ready cleared", ready, 0);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    @(negedge clk);
    check("R7 accept low disabled", accept, 0);
    push_byte(8'h66);
    check("R7 disabled push ignored", ready, 0);
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_empty_pop();
    pop_check("R5 empty data", 8'h00);
    check("R5 ready stays", ready, 0);
    check("R5 full stays", full, 0);
    push_byte(8'h77);
    pop_check("R5 state unchanged", 8'h77);
    check("R5 empty again", ready, 0);
  endtask

  task automatic t_break();
    push_byte(8'hA1);
    send_break();
    check("R6 brk set", brk_flag, 1);
    pop_check("R6 byte before break", 8'hA1);
    pop_check("R6 break byte zero", 8'h00);
    check("R6 drained", ready, 0);
    check("R10 sticky", brk_flag, 1);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    check("R10 cleared", brk_flag, 0);
  endtask

  task automatic t_break_full();
    push_byte(8'hB1);
    push_byte(8'hB2);
    push_byte(8'hB3);
    push_byte(8'hB4);
    send_break();
    check("R6 full stays", full, 1);
    pop_check("R6 keep B1", 8'hB1);
    pop_check("R6 keep B2", 8'hB2);
    pop_check("R6 keep B3", 8'hB3);
    pop_check("R6 newest replaced", 8'h00);
    check("R6 count was four", ready, 0);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
  endtask

  task automatic t_simul();
    push_byte(8'hC1);
    push_byte(8'hC2);
    check("R9 oldest visible", rd_data, 8'hC1);
    pop = 1'b1; line_valid = 1'b1; line_data = 8'hC3;
    @(negedge clk);
    pop = 1'b0; line_valid = 1'b0;
    check("R9 ready", ready, 1);
    check("R9 not full", full, 0);
    pop_check("R9 second", 8'hC2);
    pop_check("R9 new byte", 8'hC3);
    check("R9 count unchanged", ready, 0);
  endtask

  task automatic t_flush();
    push_byte(8'hD1);
    push_byte(8'hD2);
    push_byte(8'hD3);
    push_byte(8'hD4);
    do_flush();
    check("R8 ready clear", ready, 0);
    check("R8 full clear", full, 0);
    check("R8 data zero", rd_data, 8'h00);
    push_byte(8'hD5);
    pop_check("R8 fresh queue", 8'hD5);
  endtask

  task automatic t_set_wins();
    send_break();
    brk_clr = 1'b1; line_break = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0; line_break = 1'b0;
    check("R10 set wins", brk_flag, 1);
    do_flush();
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    check("R10 clear", brk_flag, 0);
  endtask

  task automatic t_brk_priority();
    line_break = 1'b1; line_valid = 1'b1; line_data = 8'hE1;
    @(negedge clk);
    line_break = 1'b0; line_valid = 1'b0;
    pop_check("R11 break byte", 8'h00);
    check("R11 line byte dropped", ready, 0);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        vectors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    @(negedge clk);
    check("R7 accept enabled", accept, 1);
    t_order();
    t_disabled();
    t_empty_pop();
    t_break();
    t_break_full();
    t_simul();
    t_flush();
    t_set_wins();
    t_brk_priority();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule